// File: doc/BRIEF.md
# SPI Register Access Slave

This block is an SPI slave in mode 0 that lets an external host reach a 64-entry register space. It oversamples SCLK, CSn and MOSI in the system clock, assembles bytes MSB first, and decodes the first byte of every transaction as a header. The header holds three fields: a direction bit, a burst bit and a 6-bit address. The block translates the header and the data bytes that follow into single-cycle accesses on a simple register bus. The bus carries register reads and writes, pushes into a transmit FIFO, and one-hot command strobe pulses.

While the header is shifted in, and during every data byte of a write, the block returns a status byte on MISO. The status byte is built from the chip-ready, state and FIFO-level inputs. A read returns its data in the byte after the header. A burst keeps an internal address counter running across the bytes that follow. The radio, the FIFO storage and the register contents all sit outside the block.

Top module: `spi_reg_slave`

## Requirements
- R1: Bytes move MSB first. While the header byte is shifted in, MISO carries the status byte. Bit 7 of the status byte is `chipRdyN`, bits 6:4 are `radioState`, and bits 3:0 are `fifoLevel`.
- R2: In the header, bit 7 is 1 for a read, bit 6 is 1 for a burst, and bits 5:0 are the address. A single write header followed by one data byte gives exactly one `regWrEn` pulse, carrying that address and that byte.
- R3: During each data byte of a write, MISO returns the status byte.
- R4: A single read gives one `regRdEn` pulse at the header address. The data appears on MISO in the byte after the header. Any later bytes in the same transaction return the status byte and cause no further bus access.
- R5: A burst write stores each data byte at the header address, then at that address plus one, and so on.
- R6: A burst read returns the data of successive addresses in successive bytes. The address counter wraps from 0x3F to 0x00.
- R7: A header with an address in 0x30–0x3D and burst = 0 is a command strobe. The direction bit does not matter. The block raises exactly one one-cycle pulse, on `strobeOut` bit (address − 0x30). It makes no register access, and any bytes that follow in the transaction have no effect.
- R8: A read header with an address in 0x30–0x3D and burst = 1 is a single status read. It makes one `regRdEn` at that address, and later bytes return the status byte.
- R9: A write to any address in 0x30–0x3D gives no `regWrEn`, no `fifoWrEn` and no strobe.
- R10: A write to address 0x3F pulses `fifoWrEn` and never `regWrEn`. In a burst write the address stays at 0x3F, so every data byte goes to the FIFO.
- R11: While CSn is high, MISO is 0 and the bus is idle. CSn rising at any point ends the transaction and discards a partly received byte. After reset there is no bus activity and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock (asynchronous) |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from the host |
| miso | output | 1 | SPI data to the host |
| chipRdyN | input | 1 | Status bit 7, low when the chip is ready |
| radioState | input | 3 | Status bits 6:4 |
| fifoLevel | input | 4 | Status bits 3:0 |
| regAddr | output | 6 | Register bus address |
| regWrEn | output | 1 | One-cycle register write pulse |
| regWrData | output | 8 | Register write data |
| regRdEn | output | 1 | One-cycle register read pulse; `regRdData` is sampled in the same cycle |
| regRdData | input | 8 | Register read data |
| fifoWrEn | output | 1 | One-cycle transmit FIFO push |
| fifoWrData | output | 8 | Byte pushed into the FIFO |
| strobeOut | output | 14 | One-hot command strobe pulses for addresses 0x30–0x3D |

## Verification
Two things can land in the same system-clock cycle. The first is the last rising SCLK edge of a byte: it completes the byte, fires the bus access and queues the next MISO byte. The second is a CSn rise that arrives before the next falling SCLK edge, or part-way through a byte. The bench provokes this by raising CSn after the header plus four bits of a data byte, and again after three bits of a header. It judges the result from the pulse counters on the bus, which must show no write. The following transaction must then start cleanly, with a fresh status byte and a correct write. The bench also sends a strobe header followed by a data byte, and checks that the strobe pulse and the byte-boundary logic do not combine into a bus access.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] STAT_LO   = 6'h30;
  localparam logic [ADDR_W-1:0] STAT_HI   = 6'h3D;
  localparam logic [ADDR_W-1:0] FIFO_ADDR = 6'h3F;
  localparam int NUM_STROBES = int'(STAT_HI) - int'(STAT_LO) + 1;

  // strobes from control to datapath, valid in the byteDone cycle
  typedef struct packed {
    logic loadAddr;   // load address counter from the header
    logic incAddr;    // step the address counter
    logic captureRd;  // latch regRdData for the next MISO byte
    logic sendData;   // next MISO byte is read data, else status
  } dpCmd_t;

  typedef enum logic [1:0] {ST_HDR, ST_WR, ST_RD, ST_SKIP} phase_t;
endpackage

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] statusByte,
  input  logic [BYTE_W-1:0] rdData,
  input  dpCmd_t            cmd,
  output logic              csHigh,
  output logic              byteDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic [ADDR_W-1:0] curAddr,
  output logic              miso
);
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic sclkPrev, csPrev;
  logic sclkS, mosiS, sclkRise, sclkFall, csFall;
  logic [BYTE_W-1:0]    rxShift, txShift, txHold;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic                 loadPending, holdIsData;
  logic [ADDR_W-1:0]    addrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosi};
      sclkPrev <= sclkS;
      csPrev   <= csHigh;
    end
  end

  assign sclkS    = sclkSync[SYNC_STAGES-1];
  assign csHigh   = csSync[SYNC_STAGES-1];
  assign mosiS    = mosiSync[SYNC_STAGES-1];
  assign sclkRise = sclkS & ~sclkPrev & ~csHigh;
  assign sclkFall = ~sclkS & sclkPrev & ~csHigh;
  assign csFall   = ~csHigh & csPrev;

  assign rxByte   = {rxShift[BYTE_W-2:0], mosiS};
  assign byteDone = sclkRise && (bitCnt == BIT_CNT_W'(BYTE_W - 1));

  // receive side
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
    end else if (csHigh) begin
      bitCnt <= '0;
    end else if (sclkRise) begin
      rxShift <= rxByte;
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  // transmit side: next byte queued at byteDone, loaded on the next falling edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift     <= '0;
      txHold      <= '0;
      holdIsData  <= 1'b0;
      loadPending <= 1'b0;
    end else if (csFall) begin
      txShift     <= statusByte;
      loadPending <= 1'b0;
    end else if (csHigh) begin
      loadPending <= 1'b0;
    end else begin
      if (byteDone) begin
        loadPending <= 1'b1;
        holdIsData  <= cmd.sendData;
        if (cmd.captureRd) txHold <= rdData;
      end
      if (sclkFall) begin
        if (loadPending) begin
          txShift     <= holdIsData ? txHold : statusByte;
          loadPending <= 1'b0;
        end else begin
          txShift <= {txShift[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  // burst address counter, wraps naturally at ADDR_W bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            addrCnt <= '0;
    else if (cmd.loadAddr) addrCnt <= rxByte[ADDR_W-1:0] + ADDR_W'(cmd.incAddr);
    else if (cmd.incAddr)  addrCnt <= addrCnt + 1'b1;
  end

  assign curAddr = addrCnt;
  assign miso    = txShift[BYTE_W-1] & ~csHigh;

  AST_LOAD_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (sclkRise && bitCnt == '0) |-> !loadPending);  // R4
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> $stable(rxShift));  // R11
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csHigh,
  input  logic                   byteDone,
  input  logic [BYTE_W-1:0]      rxByte,
  input  logic [ADDR_W-1:0]      curAddr,
  output dpCmd_t                 cmd,
  output logic                   regWrEn,
  output logic                   regRdEn,
  output logic                   fifoWrEn,
  output logic [ADDR_W-1:0]      regAddr,
  output logic [NUM_STROBES-1:0] strobeOut
);
  phase_t phase, phaseNext;
  logic burstQ, burstNext, fireStrobe;
  logic [ADDR_W-1:0] hdrAddr;
  logic hdrInStat, curInStat, curIsFifo, hdrRead, hdrBurst;

  assign hdrAddr   = rxByte[ADDR_W-1:0];
  assign hdrRead   = rxByte[BYTE_W-1];
  assign hdrBurst  = rxByte[BYTE_W-2];
  assign hdrInStat = (hdrAddr >= STAT_LO) && (hdrAddr <= STAT_HI);
  assign curInStat = (curAddr >= STAT_LO) && (curAddr <= STAT_HI);
  assign curIsFifo = (curAddr == FIFO_ADDR);

  always_comb begin
    cmd        = '0;
    regWrEn    = 1'b0;
    regRdEn    = 1'b0;
    fifoWrEn   = 1'b0;
    fireStrobe = 1'b0;
    regAddr    = curAddr;
    phaseNext  = phase;
    burstNext  = burstQ;
    if (byteDone) begin
      unique case (phase)
        ST_HDR: begin
          regAddr = hdrAddr;
          if (hdrInStat && !hdrBurst) begin
            fireStrobe = 1'b1;
            phaseNext  = ST_SKIP;
          end else begin
            burstNext    = hdrBurst && !hdrInStat;
            cmd.loadAddr = 1'b1;
            if (hdrRead) begin
              regRdEn       = 1'b1;
              cmd.captureRd = 1'b1;
              cmd.sendData  = 1'b1;
              cmd.incAddr   = burstNext;
              phaseNext     = ST_RD;
            end else begin
              phaseNext = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (curIsFifo)       fifoWrEn = 1'b1;
          else if (!curInStat) regWrEn  = 1'b1;
          if (burstQ) cmd.incAddr = !curIsFifo;
          else        phaseNext   = ST_SKIP;
        end
        ST_RD: begin
          if (burstQ) begin
            regRdEn       = 1'b1;
            cmd.captureRd = 1'b1;
            cmd.sendData  = 1'b1;
            cmd.incAddr   = 1'b1;
          end else begin
            phaseNext = ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_STROBES; k++)
      strobeOut[k] = fireStrobe && (hdrAddr == STAT_LO + ADDR_W'(k));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= ST_HDR;
      burstQ <= 1'b0;
    end else if (csHigh) begin
      phase  <= ST_HDR;
      burstQ <= 1'b0;
    end else begin
      phase  <= phaseNext;
      burstQ <= burstNext;
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobeOut));  // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (|strobeOut) |=> !(|strobeOut));  // R7
  AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && fifoWrEn));  // R10
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !((regAddr >= STAT_LO) && (regAddr <= STAT_HI)));  // R9
  AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |-> !(regWrEn || regRdEn || fifoWrEn || (|strobeOut)));  // R11
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclk,
  input  logic                   csN,
  input  logic                   mosi,
  output logic                   miso,
  input  logic                   chipRdyN,
  input  logic [2:0]             radioState,
  input  logic [3:0]             fifoLevel,
  output logic [ADDR_W-1:0]      regAddr,
  output logic                   regWrEn,
  output logic [BYTE_W-1:0]      regWrData,
  output logic                   regRdEn,
  input  logic [BYTE_W-1:0]      regRdData,
  output logic                   fifoWrEn,
  output logic [BYTE_W-1:0]      fifoWrData,
  output logic [NUM_STROBES-1:0] strobeOut
);
  dpCmd_t            cmd;
  logic              csHigh, byteDone;
  logic [BYTE_W-1:0] rxByte, statusByte;
  logic [ADDR_W-1:0] curAddr;

  assign statusByte = {chipRdyN, radioState, fifoLevel};
  assign regWrData  = rxByte;
  assign fifoWrData = rxByte;

  spi_reg_datapath #(.SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .statusByte(statusByte), .rdData(regRdData), .cmd(cmd),
    .csHigh(csHigh), .byteDone(byteDone), .rxByte(rxByte),
    .curAddr(curAddr), .miso(miso)
  );

  spi_reg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csHigh(csHigh), .byteDone(byteDone),
    .rxByte(rxByte), .curAddr(curAddr), .cmd(cmd),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .fifoWrEn(fifoWrEn),
    .regAddr(regAddr), .strobeOut(strobeOut)
  );
endmodule

// File: tb/spi_reg_slave_bench.sv
`timescale 1ns/1ps
module spi_reg_slave_bench;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, mosi = 1'b0, miso;
  logic chipRdyN = 1'b0;
  logic [2:0] radioState = 3'd5;
  logic [3:0] fifoLevel = 4'd9;
  logic [5:0] regAddr;
  logic regWrEn, regRdEn, fifoWrEn;
  logic [7:0] regWrData, regRdData, fifoWrData;
  logic [13:0] strobeOut;

  logic [7:0] mem [64];
  logic [7:0] fifoLog [8];
  int wrCount = 0, rdCount = 0, fifoCnt = 0, strobeCnt = 0;
  logic [13:0] lastStrobe = '0;
  logic prevStrobe = 1'b0, strobeWide = 1'b0;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  spi_reg_slave u_spi_reg_slave (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .chipRdyN(chipRdyN), .radioState(radioState), .fifoLevel(fifoLevel),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .fifoWrEn(fifoWrEn),
    .fifoWrData(fifoWrData), .strobeOut(strobeOut)
  );

  // external register model: status range returns 0xC0 ^ address
  assign regRdData = (regAddr >= 6'h30 && regAddr <= 6'h3D) ? (8'hC0 ^ {2'b00, regAddr})
                                                            : mem[regAddr];

  always @(posedge clk) begin
    if (rstN) begin
      if (regWrEn) begin
        wrCount <= wrCount + 1;
        mem[regAddr] <= regWrData;
      end
      if (regRdEn) rdCount <= rdCount + 1;
      if (fifoWrEn) begin
        fifoLog[fifoCnt[2:0]] <= fifoWrData;
        fifoCnt <= fifoCnt + 1;
      end
      if (|strobeOut) begin
        strobeCnt  <= strobeCnt + 1;
        lastStrobe <= strobeOut;
        if (prevStrobe) strobeWide <= 1'b1;
      end
      prevStrobe <= |strobeOut;
    end
  end

  function automatic logic [7:0] memInit(int i);
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [7:0] statusNow();
    return {chipRdyN, radioState, fifoLevel};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic spiBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    spiBits(tx, 8, rx);
  endtask

  task automatic csStart();
    @(negedge clk); csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csEnd();
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R11 miso low after reset", miso, 1'b0);
    chk("R11 no bus activity after reset", wrCount + rdCount + fifoCnt + strobeCnt, 0);
  endtask

  task automatic testSingleWrite();
    logic [7:0] r;
    int w0 = wrCount;
    csStart();
    spiByte(8'h05, r); chk("R1 status during header", r, statusNow());
    spiByte(8'hA5, r); chk("R3 status during write data", r, statusNow());
    csEnd();
    chk("R2 single write count", wrCount - w0, 1);
    chk("R2 single write data", mem[5], 8'hA5);
    chk("R11 miso low with CSn high", miso, 1'b0);
  endtask

  task automatic testSingleRead();
    logic [7:0] r;
    int r0 = rdCount;
    csStart();
    spiByte(8'h85, r); chk("R1 status during read header", r, statusNow());
    spiByte(8'h00, r); chk("R4 read data after header", r, 8'hA5);
    spiByte(8'h00, r); chk("R4 later byte returns status", r, statusNow());
    csEnd();
    chk("R4 one read access", rdCount - r0, 1);
  endtask

  task automatic testBurstWrite();
    logic [7:0] r;
    int w0 = wrCount;
    csStart();
    spiByte(8'h50, r);
    spiByte(8'h11, r); chk("R3 burst status byte 0", r, statusNow());
    spiByte(8'h22, r); chk("R3 burst status byte 1", r, statusNow());
    spiByte(8'h33, r);
    csEnd();
    chk("R5 burst write count", wrCount - w0, 3);
    chk("R5 burst addr 0x10", mem[6'h10], 8'h11);
    chk("R5 burst addr 0x11", mem[6'h11], 8'h22);
    chk("R5 burst addr 0x12", mem[6'h12], 8'h33);
  endtask

  task automatic testBurstRead();
    logic [7:0] r;
    csStart();
    spiByte(8'hD0, r);
    spiByte(8'h00, r); chk("R6 burst read 0x10", r, 8'h11);
    spiByte(8'h00, r); chk("R6 burst read 0x11", r, 8'h22);
    spiByte(8'h00, r); chk("R6 burst read 0x12", r, 8'h33);
    csEnd();
    csStart();
    spiByte(8'hFE, r);
    spiByte(8'h00, r); chk("R6 wrap read 0x3E", r, memInit(62));
    spiByte(8'h00, r); chk("R6 wrap read 0x3F", r, memInit(63));
    spiByte(8'h00, r); chk("R6 wrap read 0x00", r, memInit(0));
    csEnd();
  endtask

  task automatic testStrobe();
    logic [7:0] r;
    int w0 = wrCount, r0 = rdCount, s0 = strobeCnt, f0 = fifoCnt;
    csStart();
    spiByte(8'h36, r); chk("R1 status during strobe header", r, statusNow());
    spiByte(8'h99, r);  // trailing byte must be ignored
    csEnd();
    chk("R7 one strobe pulse", strobeCnt - s0, 1);
    chk("R7 strobe bit 6", lastStrobe, 14'h0040);
    chk("R7 strobe no bus access", (wrCount - w0) + (rdCount - r0) + (fifoCnt - f0), 0);
    csStart();
    spiByte(8'hBD, r);  // read bit set, burst clear: still a strobe
    csEnd();
    chk("R7 strobe bit 13", lastStrobe, 14'h2000);
    chk("R7 strobe single cycle", strobeWide, 1'b0);
  endtask

  task automatic testStatusRead();
    logic [7:0] r;
    int r0 = rdCount, s0 = strobeCnt;
    csStart();
    spiByte(8'hF2, r);
    spiByte(8'h00, r); chk("R8 status register value", r, 8'hF2);
    spiByte(8'h00, r); chk("R8 no burst on status", r, statusNow());
    csEnd();
    chk("R8 one read access", rdCount - r0, 1);
    chk("R8 no strobe", strobeCnt - s0, 0);
  endtask

  task automatic testStatusWriteIgnored();
    logic [7:0] r;
    int w0 = wrCount, f0 = fifoCnt, s0 = strobeCnt;
    csStart();
    spiByte(8'h75, r);
    spiByte(8'h44, r);
    spiByte(8'h45, r);
    csEnd();
    chk("R9 status write ignored", (wrCount - w0) + (fifoCnt - f0) + (strobeCnt - s0), 0);
  endtask

  task automatic testFifo();
    logic [7:0] r;
    int w0 = wrCount, f0 = fifoCnt;
    csStart();
    spiByte(8'h7F, r);
    spiByte(8'h01, r);
    spiByte(8'h02, r);
    spiByte(8'h03, r);
    csEnd();
    chk("R10 fifo push count", fifoCnt - f0, 3);
    chk("R10 no register write", wrCount - w0, 0);
    chk("R10 fifo byte 0", fifoLog[f0[2:0]], 8'h01);
    chk("R10 fifo byte 2", fifoLog[3'(f0 + 2)], 8'h03);
    chk("R10 addr 0 untouched", mem[0], memInit(0));
  endtask

  task automatic testAbort();
    logic [7:0] r;
    int w0 = wrCount;
    csStart();
    spiByte(8'h07, r);
    spiBits(8'hFF, 4, r);
    csEnd();
    chk("R11 partial byte discarded", wrCount - w0, 0);
    chipRdyN = 1'b1; radioState = 3'd2; fifoLevel = 4'd3;
    csStart();
    spiBits(8'h07, 3, r);
    csEnd();
    csStart();
    spiByte(8'h07, r); chk("R1 status after abort", r, 8'hA3);
    spiByte(8'h5A, r);
    csEnd();
    chk("R11 clean write after abort", mem[7], 8'h5A);
    chk("R11 one write after abort", wrCount - w0, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = memInit(i);
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testSingleWrite();
    testSingleRead();
    testBurstWrite();
    testBurstRead();
    testStrobe();
    testStatusRead();
    testStatusWriteIgnored();
    testFifo();
    testAbort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule